// File: doc/BRIEF.md
# Sliding-Window Pipelined Minimum

This block keeps the most recent `DEPTH` unsigned samples of a sensor stream and, on every clock, reports the smallest value in that window. A new sample, marked by a valid strobe, shifts in at the newest end of the window. The oldest sample falls off the far end. The window length is a build-time parameter and can be any value of at least 1, including values that are not powers of two.

The minimum comes from a balanced tree of two-input comparators. The tree is built recursively. A range of `n` elements splits into a lower part of `floor(n/2)` elements and an upper part of `n - floor(n/2)` elements. Every tree level ends in a register, so the logic between flops is a single compare-and-select. A branch that reaches a single element before the deepest level passes through delay registers. As a result, every operand at a given level comes from the same window snapshot. The tree starts a new window and delivers a result on every clock. The latency is a fixed `ceil(log2(DEPTH))` cycles, counted from the edge that accepts a sample.

Top module: `slide_min_pipe`

## Requirements
- R1: A sample accepted on a clock edge enters the window, and the sample accepted `DEPTH` acceptances earlier leaves it. An evicted sample no longer affects `out_min`.
- R2: Samples are compared as unsigned integers. For example, 0x7F is smaller than 0x80 when `WIDTH` = 8.
- R3: Back-to-back accepted samples produce back-to-back results. Every window state gets its own minimum on `out_min`, one per cycle.
- R4: Let an accepted sample enter the window on edge k. The minimum of that window appears on `out_min` with `out_valid` = 1 after edge k + L, where L = ceil(log2(DEPTH)). `out_valid` is 0 after edges k .. k+L-1 unless an earlier sample is still in flight.
- R5: Synchronous active-high reset fills the window and the tree with all-ones and clears `out_valid`. During warm-up, `out_min` therefore covers only the samples received since reset.
- R6: While `in_valid` is 0, the window holds its contents. `out_valid` returns to 0 once the in-flight results drain. `out_min` keeps showing the minimum of the held window.
- R7: The block is correct for any `DEPTH` >= 1. With `DEPTH` = 1 the latency is 0 and `out_min` equals the last accepted sample one edge after acceptance.
- R8: The extreme codes are handled. A 0 sample forces `out_min` to 0 while that sample is in the window. A window of all 2^WIDTH-1 values gives 2^WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_sample` is accepted on this edge |
| in_sample | input | WIDTH | Unsigned sample value |
| out_valid | output | 1 | `out_min` belongs to a window updated by an accepted sample |
| out_min | output | WIDTH | Minimum of the window, L cycles after the window changed |

## Verification
The stream patterns each expose a different fault:
- **Falling run followed by a rising run:** each new sample becomes the minimum, then a window pass must expel the smallest values one by one. Any off-by-one in window length or eviction shows up here.
- **Mixed values straddling the sign bit:** separates an unsigned comparison from a signed one.
- **A zero followed by maximum codes:** tests both extremes and the exact cycle in which the zero leaves.
- **A single isolated sample and idle gaps:** pin the latency, the drain of the valid flag, and window retention.
- **A one-element instance on the same inputs:** covers the zero-level tree.

// File: rtl/slmin_pkg.sv
package slmin_pkg;

  // Number of registered tree levels needed for n leaves.
  function automatic int tree_levels(input int n);
    int lv;
    lv = 0;
    while ((1 << lv) < n) lv++;
    return lv;
  endfunction

endpackage

// File: rtl/slmin_window.sv
module slmin_window #(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift_en,
  input  logic [WIDTH-1:0]             din,
  output logic [DEPTH-1:0][WIDTH-1:0]  taps
);

  // taps[0] is the newest sample, taps[DEPTH-1] the oldest.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '1;
    end else if (shift_en) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

endmodule

// File: rtl/slmin_delay.sv
module slmin_delay #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign dout = din;
    end else begin : g_regs
      logic [STAGES-1:0][WIDTH-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
          pipe[0] <= din;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign dout = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/slmin_cmp.sv
module slmin_cmp #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lo_op,
  input  logic [WIDTH-1:0] hi_op,
  output logic [WIDTH-1:0] q
);

  // Lower-index operand wins only when strictly smaller; ties take the upper one.
  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= (lo_op < hi_op) ? lo_op : hi_op;
  end

endmodule

// File: rtl/slmin_node.sv
module slmin_node #(
  parameter int N      = 6,
  parameter int WIDTH  = 8,
  parameter int STAGES = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N-1:0][WIDTH-1:0]  elems,
  output logic [WIDTH-1:0]         q
);

  localparam int NLO = N / 2;
  localparam int NHI = N - NLO;

  generate
    if (N == 1) begin : g_leaf
      // Leaf reached early: pad with registers so the snapshot lines up.
      slmin_delay #(.WIDTH(WIDTH), .STAGES(STAGES)) u_pad (
        .clk (clk),
        .rst (rst),
        .din (elems[0]),
        .dout(q)
      );
    end else begin : g_split
      logic [WIDTH-1:0] lo_q, hi_q;

      slmin_node #(.N(NLO), .WIDTH(WIDTH), .STAGES(STAGES-1)) u_lo (
        .clk  (clk),
        .rst  (rst),
        .elems(elems[NLO-1:0]),
        .q    (lo_q)
      );

      slmin_node #(.N(NHI), .WIDTH(WIDTH), .STAGES(STAGES-1)) u_hi (
        .clk  (clk),
        .rst  (rst),
        .elems(elems[N-1:NLO]),
        .q    (hi_q)
      );

      slmin_cmp #(.WIDTH(WIDTH)) u_cmp (
        .clk  (clk),
        .rst  (rst),
        .lo_op(lo_q),
        .hi_op(hi_q),
        .q    (q)
      );
    end
  endgenerate

endmodule

// File: rtl/slide_min_pipe.sv
module slide_min_pipe #(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_sample,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_min
);

  localparam int LEVELS = slmin_pkg::tree_levels(DEPTH);

  logic [DEPTH-1:0][WIDTH-1:0] win_taps;
  logic [LEVELS:0]             vld_pipe;

  slmin_window #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_win (
    .clk     (clk),
    .rst     (rst),
    .shift_en(in_valid),
    .din     (in_sample),
    .taps    (win_taps)
  );

  slmin_node #(.N(DEPTH), .WIDTH(WIDTH), .STAGES(LEVELS)) u_tree (
    .clk  (clk),
    .rst  (rst),
    .elems(win_taps),
    .q    (out_min)
  );

  // Valid travels alongside the data: one flop for the window, one per level.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_pipe <= '0;
    end else begin
      vld_pipe[0] <= in_valid;
      for (int i = 1; i <= LEVELS; i++) vld_pipe[i] <= vld_pipe[i-1];
    end
  end

  assign out_valid = vld_pipe[LEVELS];

endmodule

// File: rtl/slide_min_pipe_chk.sv
module slide_min_pipe_chk #(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_sample,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_min
);

  localparam int LAT = slmin_pkg::tree_levels(DEPTH);

  logic [LAT:0] acc_sh;
  logic [LAT:0] zero_sh;
  logic [7:0]   idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_sh   <= '0;
      zero_sh  <= '0;
      idle_cnt <= '0;
    end else begin
      acc_sh[0]  <= in_valid;
      zero_sh[0] <= in_valid && (in_sample == '0);
      for (int i = 1; i <= LAT; i++) begin
        acc_sh[i]  <= acc_sh[i-1];
        zero_sh[i] <= zero_sh[i-1];
      end
      if (in_valid)              idle_cnt <= '0;
      else if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 8'd1;
    end
  end

  // R5: reset leaves no valid result behind.
  assert_reset_clears_R5: assert property (@(posedge clk) rst |=> !out_valid);

  // R4: out_valid marks exactly the acceptances from LAT cycles back.
  assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid == acc_sh[LAT]);

  // R8: a zero accepted LAT cycles back must drive the minimum to zero.
  assert_zero_wins_R8: assert property (@(posedge clk) disable iff (rst)
    zero_sh[LAT] |-> (out_min == '0));

  // R6: a long idle stretch keeps the result steady.
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(idle_cnt) > LAT + 1) |-> $stable(out_min));

endmodule

bind slide_min_pipe slide_min_pipe_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_sample(in_sample),
  .out_valid(out_valid),
  .out_min  (out_min)
);

// File: tb/slide_min_pipe_tb.sv
module slide_min_pipe_tb;

  localparam int DEPTH = 6;
  localparam int WIDTH = 8;
  localparam int LAT   = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [WIDTH-1:0] in_sample;
  logic             out_valid, d1_valid;
  logic [WIDTH-1:0] out_min, d1_min;

  int n_tests = 0;
  int n_fail  = 0;

  logic [WIDTH-1:0] model_win [DEPTH];
  logic [WIDTH-1:0] stim      [64];
  logic [WIDTH-1:0] expv      [64];

  always #4 clk = ~clk;

  slide_min_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_min(out_min)
  );

  // R7: one-element window on the same inputs.
  slide_min_pipe #(.DEPTH(1), .WIDTH(WIDTH)) u_dut_d1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(d1_valid), .out_min(d1_min)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] model_push(input logic [WIDTH-1:0] s);
    logic [WIDTH-1:0] m;
    for (int i = DEPTH-1; i > 0; i--) model_win[i] = model_win[i-1];
    model_win[0] = s;
    m = '1;
    for (int i = 0; i < DEPTH; i++) if (model_win[i] < m) m = model_win[i];
    return m;
  endfunction

  function automatic logic [WIDTH-1:0] model_min();
    logic [WIDTH-1:0] m;
    m = '1;
    for (int i = 0; i < DEPTH; i++) if (model_win[i] < m) m = model_win[i];
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) model_win[i] = '1;
    check("R5 valid after reset", int'(out_valid), 0);
    check("R5 min after reset", int'(out_min), 8'hFF);
  endtask

  // Drive stim[0..n-1] back to back; check every result at its due cycle.
  task automatic run_stream(input int n, input string req);
    for (int j = 0; j <= n + LAT; j++) begin
      @(negedge clk);
      if (j - 1 - LAT >= 0) begin
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " min"}, int'(out_min), int'(expv[j-1-LAT]));
      end
      if (j >= 1 && j - 1 < n) begin
        check("R7 depth1 valid", int'(d1_valid), 1);
        check("R7 depth1 min", int'(d1_min), int'(stim[j-1]));
      end
      if (j < n) begin
        in_valid  = 1'b1;
        in_sample = stim[j];
        expv[j]   = model_push(stim[j]);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check({req, " drained"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    repeat (LAT + 2) @(negedge clk);
    check("R5 idle valid", int'(out_valid), 0);
    check("R5 idle min all-ones", int'(out_min), 8'hFF);
  endtask

  task automatic t_warmup();
    do_reset();
    stim[0] = 8'h40; stim[1] = 8'h90;
    run_stream(2, "R5 warm-up");
  endtask

  task automatic t_latency();
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_sample = 8'h10;
    void'(model_push(8'h10));
    for (int e = 0; e <= LAT + 1; e++) begin
      @(negedge clk);
      in_valid = 1'b0;
      check("R4 valid timing", int'(out_valid), (e == LAT) ? 1 : 0);
      if (e < LAT)  check("R4 min before due", int'(out_min), 8'hFF);
      if (e >= LAT) check("R4 min at due", int'(out_min), 8'h10);
    end
  endtask

  task automatic t_evict();
    do_reset();
    for (int i = 0; i < 6; i++) stim[i] = 8'h60 - 8'(i * 16);
    for (int i = 6; i < 14; i++) stim[i] = 8'h70 + 8'(i);
    run_stream(14, "R1 R3 evict");
  endtask

  task automatic t_unsigned();
    do_reset();
    stim[0] = 8'h80; stim[1] = 8'hFE; stim[2] = 8'h7F;
    stim[3] = 8'hC0; stim[4] = 8'h81; stim[5] = 8'hFF;
    stim[6] = 8'h90; stim[7] = 8'hA0; stim[8] = 8'h85;
    run_stream(9, "R2 unsigned");
  endtask

  task automatic t_extreme();
    do_reset();
    stim[0] = 8'h00;
    for (int i = 1; i < 9; i++) stim[i] = 8'hFF;
    run_stream(9, "R8 extremes");
    check("R8 all-ones window", int'(out_min), 8'hFF);
  endtask

  task automatic t_idle();
    do_reset();
    stim[0] = 8'h33; stim[1] = 8'h21; stim[2] = 8'h57;
    run_stream(3, "R6 before idle");
    repeat (5) @(negedge clk);
    check("R6 idle valid low", int'(out_valid), 0);
    check("R6 idle min held", int'(out_min), int'(model_min()));
    stim[0] = 8'h44;
    run_stream(1, "R6 window kept");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    t_reset();
    t_warmup();
    t_latency();
    t_evict();
    t_unsigned();
    t_extreme();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule